// File: doc/BRIEF.md
# Logic-Block Operand Connection Box

The connection box sits in front of a tile's arithmetic logic block and chooses the two operand buses that block works on. It sees eight candidate buses, all the same width. Four are direct links that carry the low-half (LSB) result of each neighbouring logic block: north, south, east and west. The other four are the routing buses that arrive from the adjacent switch boxes in the same four directions. Two separate 8:1 bus multiplexers pick operand A and operand B from this shared set. The data path is purely combinational, so an operand follows its selected input within the same cycle.

The only state is a 6-bit configuration word. Three bits select operand A and three bits select operand B. The word is loaded one bit per clock through a serial chain while the load enable is high. Its oldest bit is presented on a chain output so that many boxes can be daisy-chained. Because one select code steers a whole bus, a bus-wide crossbar needs only six configuration bits.

Top module: `cbox_top`

## Requirements
- R1: Select codes 0, 1, 2 and 3 route the direct LSB link from the north, south, east and west neighbour, in that order, to the operand.
- R2: Select codes 4, 5, 6 and 7 route the switch-box bus from the north, south, east and west side, in that order, to the operand.
- R3: Operand A and operand B each have their own 3-bit select and choose from the same eight candidates independently of each other.
- R4: Both operands may hold the same select code; opA then equals opB.
- R5: On each rising clock edge with cfgEn high, cfgIn is shifted into the configuration word. Of the last six bits captured, the first three (most significant bit first) form the operand A select and the last three (most significant bit first) form the operand B select.
- R6: cfgOut is a registered output that shows the oldest of the six bits currently held in the configuration word, so the word can be passed on to the next box in a chain.
- R7: While cfgEn is low, the configuration word and cfgOut are held on every clock edge, whatever cfgIn does.
- R8: Reset (rstN low, asynchronous) clears the configuration word. Both operands then select the north LSB link (code 0) and cfgOut is 0.
- R9: The operand path has no register: a change on the selected input appears on the operand in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgIn | input | 1 | Serial configuration bit in |
| cfgOut | output | 1 | Serial configuration bit out, to the next box |
| lsbNorth | input | DATA_W | LSB result of the north neighbour logic block |
| lsbSouth | input | DATA_W | LSB result of the south neighbour logic block |
| lsbEast | input | DATA_W | LSB result of the east neighbour logic block |
| lsbWest | input | DATA_W | LSB result of the west neighbour logic block |
| sbNorth | input | DATA_W | Bus from the north switch box |
| sbSouth | input | DATA_W | Bus from the south switch box |
| sbEast | input | DATA_W | Bus from the east switch box |
| sbWest | input | DATA_W | Bus from the west switch box |
| opA | output | DATA_W | Selected operand A |
| opB | output | DATA_W | Selected operand B |

## Verification
Operand results are due in the same cycle as their stimulus. The bench changes data inputs just after a falling edge and samples both operands one time unit later, with no rising edge in between. A new select code or cfgOut value is due after the first rising edge that captures the bit. The bench therefore shifts a bit on one rising edge and checks at the following falling edge. Expected selects and cfgOut come from a bench-side history of the last six captured bits, so each partial load along the way is checked as well as the final word.

// File: rtl/cbox_pkg.sv
package cbox_pkg;
  localparam int NUM_CAND = 8;
  localparam int SEL_W    = $clog2(NUM_CAND);
  localparam int NUM_OPS  = 2;
  localparam int CFG_W    = NUM_OPS * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    CAND_LSB_N = 3'd0,
    CAND_LSB_S = 3'd1,
    CAND_LSB_E = 3'd2,
    CAND_LSB_W = 3'd3,
    CAND_SB_N  = 3'd4,
    CAND_SB_S  = 3'd5,
    CAND_SB_E  = 3'd6,
    CAND_SB_W  = 3'd7
  } candCode_e;

  typedef struct packed {
    logic [SEL_W-1:0] selA;
    logic [SEL_W-1:0] selB;
  } cboxSel_t;
endpackage

// File: rtl/cbox_ctrl.sv
module cbox_ctrl
  import cbox_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgEn,
  input  logic     cfgIn,
  output logic     cfgOut,
  output cboxSel_t sel
);
  logic [CFG_W-1:0] cfgReg;

  // serial chain: newest bit enters at the bottom, oldest leaves at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgEn) begin
      cfgReg <= {cfgReg[CFG_W-2:0], cfgIn};
    end
  end

  assign cfgOut   = cfgReg[CFG_W-1];
  assign sel.selA = cfgReg[CFG_W-1 -: SEL_W];
  assign sel.selB = cfgReg[SEL_W-1:0];
endmodule

// File: rtl/cbox_datapath.sv
module cbox_datapath
  import cbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cboxSel_t          sel,
  input  logic [DATA_W-1:0] lsbNorth,
  input  logic [DATA_W-1:0] lsbSouth,
  input  logic [DATA_W-1:0] lsbEast,
  input  logic [DATA_W-1:0] lsbWest,
  input  logic [DATA_W-1:0] sbNorth,
  input  logic [DATA_W-1:0] sbSouth,
  input  logic [DATA_W-1:0] sbEast,
  input  logic [DATA_W-1:0] sbWest,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  logic [DATA_W-1:0] candBus [NUM_CAND];
  logic [DATA_W-1:0] muxOut  [NUM_OPS];

  assign candBus[CAND_LSB_N] = lsbNorth;
  assign candBus[CAND_LSB_S] = lsbSouth;
  assign candBus[CAND_LSB_E] = lsbEast;
  assign candBus[CAND_LSB_W] = lsbWest;
  assign candBus[CAND_SB_N]  = sbNorth;
  assign candBus[CAND_SB_S]  = sbSouth;
  assign candBus[CAND_SB_E]  = sbEast;
  assign candBus[CAND_SB_W]  = sbWest;

  // one bus-wide 8:1 multiplexer per operand
  for (genvar p = 0; p < NUM_OPS; p++) begin : gOpMux
    logic [SEL_W-1:0] portSel;
    assign portSel = (p == 0) ? sel.selA : sel.selB;
    always_comb begin
      muxOut[p] = candBus[portSel];
    end
  end

  assign opA = muxOut[0];
  assign opB = muxOut[1];
endmodule

// File: rtl/cbox_top.sv
module cbox_top
  import cbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEn,
  input  logic              cfgIn,
  output logic              cfgOut,
  input  logic [DATA_W-1:0] lsbNorth,
  input  logic [DATA_W-1:0] lsbSouth,
  input  logic [DATA_W-1:0] lsbEast,
  input  logic [DATA_W-1:0] lsbWest,
  input  logic [DATA_W-1:0] sbNorth,
  input  logic [DATA_W-1:0] sbSouth,
  input  logic [DATA_W-1:0] sbEast,
  input  logic [DATA_W-1:0] sbWest,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  cboxSel_t selBus;

  cbox_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgEn  (cfgEn),
    .cfgIn  (cfgIn),
    .cfgOut (cfgOut),
    .sel    (selBus)
  );

  cbox_datapath #(.DATA_W(DATA_W)) uData (
    .sel      (selBus),
    .lsbNorth (lsbNorth),
    .lsbSouth (lsbSouth),
    .lsbEast  (lsbEast),
    .lsbWest  (lsbWest),
    .sbNorth  (sbNorth),
    .sbSouth  (sbSouth),
    .sbEast   (sbEast),
    .sbWest   (sbWest),
    .opA      (opA),
    .opB      (opB)
  );
endmodule

// File: rtl/cbox_checker.sv
module cbox_checker
  import cbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEn,
  input logic              cfgIn,
  input logic              cfgOut,
  input logic [DATA_W-1:0] lsbNorth,
  input logic [DATA_W-1:0] lsbSouth,
  input logic [DATA_W-1:0] lsbEast,
  input logic [DATA_W-1:0] lsbWest,
  input logic [DATA_W-1:0] sbNorth,
  input logic [DATA_W-1:0] sbSouth,
  input logic [DATA_W-1:0] sbEast,
  input logic [DATA_W-1:0] sbWest,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB
);
  // shadow of the configuration word, built only from the port activity
  logic [CFG_W-1:0] shadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadow <= '0;
    else if (cfgEn) shadow <= {shadow[CFG_W-2:0], cfgIn};
  end

  function automatic logic [DATA_W-1:0] pick(input logic [SEL_W-1:0] code);
    case (code)
      3'd0: pick = lsbNorth;
      3'd1: pick = lsbSouth;
      3'd2: pick = lsbEast;
      3'd3: pick = lsbWest;
      3'd4: pick = sbNorth;
      3'd5: pick = sbSouth;
      3'd6: pick = sbEast;
      default: pick = sbWest;
    endcase
  endfunction

  logic [SEL_W-1:0] expSelA, expSelB;
  assign expSelA = shadow[CFG_W-1 -: SEL_W];
  assign expSelB = shadow[SEL_W-1:0];

  assert_lsb_links_R1: assert property (@(posedge clk) disable iff (!rstN)
    (expSelA[SEL_W-1] == 1'b0) |-> (opA == pick(expSelA)));

  assert_sb_buses_R2: assert property (@(posedge clk) disable iff (!rstN)
    (expSelA[SEL_W-1] == 1'b1) |-> (opA == pick(expSelA)));

  assert_opb_indep_R3: assert property (@(posedge clk) disable iff (!rstN)
    opB == pick(expSelB));

  assert_same_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (expSelA == expSelB) |-> (opA == opB));

  assert_chain_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> (cfgOut == $past(shadow[CFG_W-2])));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(cfgOut));

  assert_reset_R8: assert property (@(posedge clk)
    !rstN |-> (cfgOut == 1'b0 && opA == lsbNorth && opB == lsbNorth));
endmodule

bind cbox_top cbox_checker #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_cbox_top.sv
module sim_cbox_top;
  import cbox_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN, cfgEn, cfgIn;
  logic cfgOut;
  logic [DW-1:0] lsbNorth, lsbSouth, lsbEast, lsbWest;
  logic [DW-1:0] sbNorth, sbSouth, sbEast, sbWest;
  logic [DW-1:0] opA, opB;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbox_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgIn(cfgIn), .cfgOut(cfgOut),
    .lsbNorth(lsbNorth), .lsbSouth(lsbSouth), .lsbEast(lsbEast), .lsbWest(lsbWest),
    .sbNorth(sbNorth), .sbSouth(sbSouth), .sbEast(sbEast), .sbWest(sbWest),
    .opA(opA), .opB(opB)
  );

  typedef struct {
    string         tag;
    logic [DW-1:0] expA;
    logic [DW-1:0] expB;
    logic          expOut;
  } item_t;

  item_t sbq[$];
  bit    histBits[$];
  event  sampleEv;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // candidate order from R1 and R2
  function automatic logic [DW-1:0] pick(input logic [2:0] code);
    case (code)
      3'd0: pick = lsbNorth;
      3'd1: pick = lsbSouth;
      3'd2: pick = lsbEast;
      3'd3: pick = lsbWest;
      3'd4: pick = sbNorth;
      3'd5: pick = sbSouth;
      3'd6: pick = sbEast;
      default: pick = sbWest;
    endcase
  endfunction

  // driver side: expected values from the last six captured bits (R5, R6)
  task automatic check(input string tag);
    item_t it;
    logic [2:0] a, b;
    a = {histBits[0], histBits[1], histBits[2]};
    b = {histBits[3], histBits[4], histBits[5]};
    it.tag = tag;
    it.expA = pick(a);
    it.expB = pick(b);
    it.expOut = histBits[0];
    sbq.push_back(it);
    -> sampleEv;
    #2;
  endtask

  // monitor side
  initial begin
    forever begin
      item_t it;
      @(sampleEv);
      #1;
      it = sbq.pop_front();
      checks++;
      if (opA !== it.expA || opB !== it.expB || cfgOut !== it.expOut) begin
        errors++;
        $display("FAIL %s: opA=%h opB=%h cfgOut=%b expected opA=%h opB=%h cfgOut=%b",
                 it.tag, opA, opB, cfgOut, it.expA, it.expB, it.expOut);
      end
    end
  end

  task automatic shiftBit(input bit b, input string tag);
    @(negedge clk);
    cfgEn = 1'b1;
    cfgIn = b;
    @(posedge clk);
    histBits.push_back(b);
    void'(histBits.pop_front());
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    check(tag);
  endtask

  task automatic loadCfg(input logic [2:0] a, input logic [2:0] b, input string tag);
    for (int i = 2; i >= 0; i--) shiftBit(a[i], "R5 R6 partial load A");
    for (int i = 2; i >= 0; i--) shiftBit(b[i], "R5 R6 partial load B");
    check(tag);
  endtask

  task automatic newData(input logic [DW-1:0] seed);
    @(negedge clk);
    lsbNorth = seed ^ 16'h1111;
    lsbSouth = seed ^ 16'h2222;
    lsbEast  = seed ^ 16'h3333;
    lsbWest  = seed ^ 16'h4444;
    sbNorth  = seed ^ 16'h5555;
    sbSouth  = seed ^ 16'h6666;
    sbEast   = seed ^ 16'h7777;
    sbWest   = seed ^ 16'h8888;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    cfgEn = 1'b0;
    cfgIn = 1'b0;
    for (int i = 0; i < 6; i++) histBits.push_back(1'b0);
    newData(16'h0000);
    repeat (2) @(posedge clk);
    #1;
    check("R8 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R8 after reset release");

    // R1: direct LSB links on A, switch-box codes on B
    for (int c = 0; c < 4; c++) begin
      loadCfg(3'(c), 3'(7 - c), "R1 LSB link select");
      newData(16'h0A5A + 16'(c));
      check("R1 LSB link new data");
    end

    // R2: switch-box buses on A
    for (int c = 4; c < 8; c++) begin
      loadCfg(3'(c), 3'(c - 4), "R2 switch-box select");
      newData(16'hC3C3 ^ 16'(c));
      check("R2 switch-box new data");
    end

    // R3: independent selects, R4: same select
    loadCfg(3'd5, 3'd2, "R3 independent selects");
    loadCfg(3'd6, 3'd6, "R4 same select both operands");
    newData(16'hBEEF);
    check("R4 same select new data");

    // R9: combinational follow of the selected input, no clock edge between
    @(negedge clk);
    sbEast = 16'h1234;
    #1;
    check("R9 same-cycle follow");
    sbEast = 16'hFEDC;
    #1;
    check("R9 second change");

    // R7: hold while cfgEn low, cfgIn toggling
    loadCfg(3'd3, 3'd5, "R7 setup");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfgEn = 1'b0;
      cfgIn = ~cfgIn;
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R7 hold with cfgIn toggling");
    end

    // chain continuity: a second word pushes the first out through cfgOut (R6)
    loadCfg(3'd1, 3'd4, "R6 chained word");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule